// File: doc/BRIEF.md
# Instanced Draw Coalescing Unit

This unit sits behind a command macro engine and watches the stream of draw-related method writes it produces. Each draw arrives as a group of three writes: a draw-begin, a vertex-count or index-count write, and a draw-end. When several groups in a row use the same draw mode and the same element count, and instancing is turned on, the unit folds them into one command that carries an instance count. It issues that command only when the run of matching groups ends.

The run ends in one of three ways: a count write that does not match, a method that has nothing to do with drawing, or the end of the macro. On that flush the unit presents a command with the mode (array or indexed), the element count, the instance count, and a flag. The flag marks that the number of draw-end writes seen did not match the instance count. Methods that are not draw methods are passed on one cycle after they are accepted. Any pending flush is placed in the command slot first.

The command output uses a valid/ready handshake. While a command waits in the slot, the method input is held off. The unit also keeps the last vertex-count and index-count values. It clears the one used by a batch when that batch is flushed.

Top module: `draw_coalescer`

## Requirements
- R1: After reset, `cmd_valid`, `fwd_valid` and `illegal_inst` are low, `in_ready` is high, and both count registers read zero.
- R2: Method kind codes on `in_kind` are 0 = other, 1 = draw begin, 2 = draw end, 3 = vertex count, 4 = index count, 5 = macro end. Command mode codes on `cmd_mode` are 1 = array and 2 = indexed; 0 (undefined) never appears on a valid command. A count write with no batch open and a begin pending opens a batch with that mode and count and one instance, and produces no command.
- R3: A count write during an open batch that has the same mode and the same count, with instancing latched and a begin pending, adds one instance and produces no command.
- R4: Any other count write during an open batch flushes the batch in that cycle. Because the flush clears the pending begin, that write does not open a new batch.
- R5: Each draw-end write adds one to an end counter, which a new batch zeroes. At flush, `cmd_end_mismatch` is high exactly when the instance count differs from the end counter.
- R6: A method of kind other, accepted while a batch is open, flushes the batch. The command is valid in the cycle after acceptance. In that same cycle `fwd_valid` pulses for one cycle and `fwd_data` equals the accepted argument.
- R7: A macro-end write flushes an open batch and is not forwarded. With no batch open it produces no command.
- R8: A count write stores its argument in the count register for its mode. A flush zeroes the register for the flushed batch's mode, and this overrides a write to that register in the same cycle. The register for the other mode keeps its value.
- R9: A draw-begin with both the instance-next and instance-continue bits set raises `illegal_inst` for exactly one cycle, in the cycle after acceptance. Otherwise `illegal_inst` stays low.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay stable and `in_ready` is low.
- R11: A draw-begin with both instance bits clear turns instancing off for the next group. A matching count write then flushes the batch instead of merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Method write offered |
| in_ready | output | 1 | Method write can be taken |
| in_kind | input | 3 | Method kind code |
| in_arg | input | COUNT_W | Method argument (count, or data to forward) |
| inst_next | input | 1 | Instance-next bit, sampled with draw-begin |
| inst_cont | input | 1 | Instance-continue bit, sampled with draw-begin |
| cmd_valid | output | 1 | Draw command present |
| cmd_ready | input | 1 | Draw command taken |
| cmd_mode | output | 2 | Draw mode of command |
| cmd_count | output | COUNT_W | Element count of command |
| cmd_instances | output | INST_W | Instance count of command |
| cmd_end_mismatch | output | 1 | End count differed from instance count |
| fwd_valid | output | 1 | One-cycle pulse for a forwarded non-draw method |
| fwd_data | output | COUNT_W | Argument of the forwarded method |
| illegal_inst | output | 1 | Pulse for a begin with both instance bits set |
| vtx_count | output | COUNT_W | Vertex-count register |
| idx_count | output | COUNT_W | Index-count register |

## Verification
A method write is accepted on the rising edge where `in_valid` and `in_ready` are both high. The flushed command, the forward pulse, the illegal pulse and the count registers all take their new values at that same edge, so each one is due one cycle after acceptance. The bench drives inputs on the falling edge, checks `in_ready` there before it lets a rising edge pass, and reads results on the following falling edge. The monitor takes a command off the expected queue only on a falling edge where `cmd_valid` and `cmd_ready` are both high. During the stall test, `cmd_ready` is raised just after a rising edge, so the pop happens exactly once.

// File: rtl/draw_coalesce_pkg.sv
package draw_coalesce_pkg;

  typedef enum logic [2:0] {
    K_OTHER  = 3'd0,
    K_BEGIN  = 3'd1,
    K_END    = 3'd2,
    K_VCOUNT = 3'd3,
    K_ICOUNT = 3'd4,
    K_MEND   = 3'd5
  } meth_kind_e;

  typedef enum logic [1:0] {
    M_UNDEF = 2'd0,
    M_ARRAY = 2'd1,
    M_INDEX = 2'd2
  } draw_mode_e;

endpackage

// File: rtl/coalesce_rst_sync.sv
module coalesce_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/coalesce_tracker.sv
module coalesce_tracker
  import draw_coalesce_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int INST_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  meth_kind_e         kind,
  input  logic [COUNT_W-1:0] arg,
  input  logic               inst_next,
  input  logic               inst_cont,
  output logic               flush,
  output draw_mode_e         flush_mode,
  output logic [COUNT_W-1:0] flush_count,
  output logic [INST_W-1:0]  flush_inst,
  output logic               flush_err
);
  localparam logic [INST_W-1:0] ONE = INST_W'(1);

  draw_mode_e          mode_q, mode_d;
  logic [COUNT_W-1:0]  cnt_q, cnt_d;
  logic [INST_W-1:0]   inst_q, inst_d;
  logic [INST_W-1:0]   endc_q, endc_d;
  logic                imode_q, imode_d;
  logic                pend_q, pend_d;

  logic       is_cnt, active, merge, start;
  draw_mode_e want_mode;

  always_comb begin
    is_cnt    = (kind == K_VCOUNT) || (kind == K_ICOUNT);
    want_mode = (kind == K_ICOUNT) ? M_INDEX : M_ARRAY;
    active    = (mode_q != M_UNDEF);
    merge     = is_cnt && active && (mode_q == want_mode) && (arg == cnt_q)
                && imode_q && pend_q;
    flush     = accept && active &&
                ((is_cnt && !merge) || (kind == K_OTHER) || (kind == K_MEND));
    start     = is_cnt && !active && pend_q;
  end

  assign flush_mode  = mode_q;
  assign flush_count = cnt_q;
  assign flush_inst  = inst_q;
  assign flush_err   = (inst_q != endc_q);

  always_comb begin
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    inst_d  = inst_q;
    endc_d  = endc_q;
    imode_d = imode_q;
    pend_d  = pend_q;
    if (accept) begin
      if (flush) begin
        mode_d  = M_UNDEF;
        cnt_d   = '0;
        inst_d  = '0;
        endc_d  = '0;
        imode_d = 1'b0;
        pend_d  = 1'b0;
      end else if (kind == K_BEGIN) begin
        imode_d = inst_next || inst_cont;
        pend_d  = 1'b1;
      end else if (kind == K_END) begin
        endc_d  = endc_q + ONE;
      end else if (start) begin
        mode_d  = want_mode;
        cnt_d   = arg;
        inst_d  = ONE;
        endc_d  = '0;
        pend_d  = 1'b0;
      end else if (merge) begin
        inst_d  = inst_q + ONE;
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_UNDEF;
      cnt_q   <= '0;
      inst_q  <= '0;
      endc_q  <= '0;
      imode_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (accept) begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      inst_q  <= inst_d;
      endc_q  <= endc_d;
      imode_q <= imode_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/coalesce_cmd_slot.sv
module coalesce_cmd_slot
  import draw_coalesce_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int INST_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  draw_mode_e         ld_mode,
  input  logic [COUNT_W-1:0] ld_count,
  input  logic [INST_W-1:0]  ld_inst,
  input  logic               ld_err,
  input  logic               ready,
  output logic               valid,
  output draw_mode_e         mode,
  output logic [COUNT_W-1:0] count,
  output logic [INST_W-1:0]  inst,
  output logic               err
);
  logic valid_d;

  always_comb begin
    if (load)                valid_d = 1'b1;
    else if (valid && ready) valid_d = 1'b0;
    else                     valid_d = valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_UNDEF;
      count <= '0;
      inst  <= '0;
      err   <= 1'b0;
    end else if (load) begin
      mode  <= ld_mode;
      count <= ld_count;
      inst  <= ld_inst;
      err   <= ld_err;
    end
  end
endmodule

// File: rtl/coalesce_side_regs.sv
module coalesce_side_regs
  import draw_coalesce_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  meth_kind_e         kind,
  input  logic [COUNT_W-1:0] arg,
  input  logic               inst_next,
  input  logic               inst_cont,
  input  logic               flush,
  input  draw_mode_e         flush_mode,
  output logic [COUNT_W-1:0] vtx_q,
  output logic [COUNT_W-1:0] idx_q,
  output logic               fwd_q,
  output logic [COUNT_W-1:0] fwd_data_q,
  output logic               illegal_q
);
  logic [COUNT_W-1:0] vtx_d, idx_d;
  logic               fwd_d, illegal_d;

  always_comb begin
    vtx_d = vtx_q;
    idx_d = idx_q;
    if (accept && kind == K_VCOUNT) vtx_d = arg;
    if (accept && kind == K_ICOUNT) idx_d = arg;
    if (flush && flush_mode == M_ARRAY) vtx_d = '0;
    if (flush && flush_mode == M_INDEX) idx_d = '0;
    fwd_d     = accept && (kind == K_OTHER);
    illegal_d = accept && (kind == K_BEGIN) && inst_next && inst_cont;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtx_q     <= '0;
      idx_q     <= '0;
      fwd_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      vtx_q     <= vtx_d;
      idx_q     <= idx_d;
      fwd_q     <= fwd_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fwd_data_q <= '0;
    else if (fwd_d)   fwd_data_q <= arg;
  end
endmodule

// File: rtl/draw_coalescer.sv
module draw_coalescer
  import draw_coalesce_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int INST_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_kind,
  input  logic [COUNT_W-1:0] in_arg,
  input  logic               inst_next,
  input  logic               inst_cont,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_mode,
  output logic [COUNT_W-1:0] cmd_count,
  output logic [INST_W-1:0]  cmd_instances,
  output logic               cmd_end_mismatch,
  output logic               fwd_valid,
  output logic [COUNT_W-1:0] fwd_data,
  output logic               illegal_inst,
  output logic [COUNT_W-1:0] vtx_count,
  output logic [COUNT_W-1:0] idx_count
);
  logic               rst_n_s;
  logic               accept;
  meth_kind_e         kind;
  logic               flush;
  draw_mode_e         fl_mode, slot_mode;
  logic [COUNT_W-1:0] fl_count;
  logic [INST_W-1:0]  fl_inst;
  logic               fl_err;

  coalesce_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign kind     = meth_kind_e'(in_kind);
  assign in_ready = rst_n_s && !cmd_valid;
  assign accept   = in_valid && in_ready;

  coalesce_tracker #(.COUNT_W(COUNT_W), .INST_W(INST_W)) u_trk (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .kind(kind), .arg(in_arg),
    .inst_next(inst_next), .inst_cont(inst_cont), .flush(flush),
    .flush_mode(fl_mode), .flush_count(fl_count), .flush_inst(fl_inst),
    .flush_err(fl_err)
  );

  coalesce_cmd_slot #(.COUNT_W(COUNT_W), .INST_W(INST_W)) u_slot (
    .clk(clk), .rst_n(rst_n_s), .load(flush), .ld_mode(fl_mode),
    .ld_count(fl_count), .ld_inst(fl_inst), .ld_err(fl_err),
    .ready(cmd_ready), .valid(cmd_valid), .mode(slot_mode),
    .count(cmd_count), .inst(cmd_instances), .err(cmd_end_mismatch)
  );

  assign cmd_mode = slot_mode;

  coalesce_side_regs #(.COUNT_W(COUNT_W)) u_side (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .kind(kind), .arg(in_arg),
    .inst_next(inst_next), .inst_cont(inst_cont), .flush(flush),
    .flush_mode(fl_mode), .vtx_q(vtx_count), .idx_q(idx_count),
    .fwd_q(fwd_valid), .fwd_data_q(fwd_data), .illegal_q(illegal_inst)
  );
endmodule

// File: rtl/draw_coalescer_chk.sv
module draw_coalescer_chk #(
  parameter int COUNT_W = 32,
  parameter int INST_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2:0]         in_kind,
  input logic [COUNT_W-1:0] in_arg,
  input logic               inst_next,
  input logic               inst_cont,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_mode,
  input logic [COUNT_W-1:0] cmd_count,
  input logic [INST_W-1:0]  cmd_instances,
  input logic               fwd_valid,
  input logic [COUNT_W-1:0] fwd_data,
  input logic               illegal_inst,
  input logic [COUNT_W-1:0] vtx_count
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_count)
                                && $stable(cmd_instances) && $stable(cmd_mode));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !in_ready);

  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == 3'd1 && inst_next && inst_cont |=> illegal_inst);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_kind == 3'd1 && inst_next && inst_cont) |=> !illegal_inst);

  p_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == 3'd0 |=> fwd_valid && fwd_data == $past(in_arg));

  p_nofwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == 3'd5 |=> !fwd_valid);

  p_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_mode != 2'd0 && cmd_instances != '0);

  p_vwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == 3'd3 |=> vtx_count == $past(in_arg) || vtx_count == '0);
endmodule

bind draw_coalescer draw_coalescer_chk #(.COUNT_W(COUNT_W), .INST_W(INST_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .in_arg(in_arg), .inst_next(inst_next),
  .inst_cont(inst_cont), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_mode(cmd_mode), .cmd_count(cmd_count), .cmd_instances(cmd_instances),
  .fwd_valid(fwd_valid), .fwd_data(fwd_data), .illegal_inst(illegal_inst),
  .vtx_count(vtx_count)
);

// File: tb/test_draw_coalescer.sv
module test_draw_coalescer;
  localparam int CW = 32;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready;
  logic [2:0]    in_kind;
  logic [CW-1:0] in_arg;
  logic          inst_next, inst_cont;
  logic          cmd_valid, cmd_ready;
  logic [1:0]    cmd_mode;
  logic [CW-1:0] cmd_count;
  logic [IW-1:0] cmd_instances;
  logic          cmd_end_mismatch;
  logic          fwd_valid;
  logic [CW-1:0] fwd_data;
  logic          illegal_inst;
  logic [CW-1:0] vtx_count, idx_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]    mode;
    logic [CW-1:0] count;
    logic [IW-1:0] inst;
    logic          err;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  draw_coalescer #(.COUNT_W(CW), .INST_W(IW)) i_draw_coalescer (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [1:0] m, input logic [CW-1:0] c,
                            input logic [IW-1:0] n, input logic e);
    exp_q.push_back('{mode: m, count: c, inst: n, err: e});
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected command actual=%0d/%0d/%0d expected=none",
                 cmd_mode, cmd_count, cmd_instances);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (cmd_mode !== e.mode || cmd_count !== e.count ||
            cmd_instances !== e.inst || cmd_end_mismatch !== e.err) begin
          errors++;
          $display("FAIL R3/R5 command actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                   cmd_mode, cmd_count, cmd_instances, cmd_end_mismatch,
                   e.mode, e.count, e.inst, e.err);
        end
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [CW-1:0] a,
                      input logic nx, input logic ct);
    in_kind = k; in_arg = a; inst_next = nx; inst_cont = ct; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic group(input logic [2:0] k, input logic [CW-1:0] c,
                       input logic nx, input logic ct);
    send(3'd1, '0, nx, ct);
    send(k, c, 1'b0, 1'b0);
    send(3'd2, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_arg = '0;
    inst_next = 1'b0; inst_cont = 1'b0; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 fwd_valid", fwd_valid, 0);
    check("R1 illegal", illegal_inst, 0);
    check("R1 counts", {vtx_count, idx_count}, 0);

    // R2/R3 three merged instanced array groups, flushed by other method (R6)
    group(3'd3, 6, 1'b1, 1'b0);
    check("R2 no command after first group", cmd_valid, 0);
    group(3'd3, 6, 1'b1, 1'b0);
    group(3'd3, 6, 1'b1, 1'b0);
    check("R3 still merging", cmd_valid, 0);
    expect_cmd(2'd1, 6, 3, 1'b0);
    send(3'd0, 32'hA5A5, 1'b0, 1'b0);
    check("R6 fwd pulse", fwd_valid, 1);
    check("R6 fwd data", fwd_data, 32'hA5A5);
    check("R6 cmd with fwd", cmd_valid, 1);
    check("R8 vertex reg zeroed", vtx_count, 0);
    @(negedge clk);
    check("R6 fwd one cycle", fwd_valid, 0);

    // R11 instancing off: matching count flushes, no new batch (R4)
    group(3'd4, 9, 1'b0, 1'b0);
    send(3'd1, '0, 1'b0, 1'b0);
    expect_cmd(2'd2, 9, 1, 1'b0);
    send(3'd4, 9, 1'b0, 1'b0);
    check("R11 flush on non-instanced", cmd_valid, 1);
    check("R8 index reg zero wins", idx_count, 0);
    @(negedge clk);
    send(3'd5, '0, 1'b0, 1'b0);
    check("R7 idle macro end no cmd", cmd_valid, 0);
    check("R7 macro end not forwarded", fwd_valid, 0);

    // R4 count mismatch
    group(3'd3, 4, 1'b0, 1'b1);
    send(3'd1, '0, 1'b0, 1'b1);
    expect_cmd(2'd1, 4, 1, 1'b0);
    send(3'd3, 5, 1'b0, 1'b0);
    check("R8 vertex zero wins on mismatch", vtx_count, 0);
    @(negedge clk);
    send(3'd3, 11, 1'b0, 1'b0);
    check("R4 no batch opened", cmd_valid, 0);
    check("R8 vertex holds write", vtx_count, 11);
    send(3'd5, '0, 1'b0, 1'b0);
    check("R4 no cmd on macro end", cmd_valid, 0);

    // R5 missing end, flushed by macro end (R7)
    send(3'd1, '0, 1'b1, 1'b0);
    send(3'd3, 7, 1'b0, 1'b0);
    expect_cmd(2'd1, 7, 1, 1'b1);
    send(3'd5, '0, 1'b0, 1'b0);
    check("R7 macro end flush", cmd_valid, 1);
    check("R7 no fwd", fwd_valid, 0);
    @(negedge clk);

    // R5 merged with one end missing
    group(3'd3, 8, 1'b1, 1'b0);
    send(3'd1, '0, 1'b1, 1'b0);
    send(3'd3, 8, 1'b0, 1'b0);
    expect_cmd(2'd1, 8, 2, 1'b1);
    send(3'd0, 32'h33, 1'b0, 1'b0);
    @(negedge clk);

    // R4/R8 mode change keeps other register
    group(3'd3, 3, 1'b1, 1'b0);
    send(3'd1, '0, 1'b1, 1'b0);
    expect_cmd(2'd1, 3, 1, 1'b0);
    send(3'd4, 3, 1'b0, 1'b0);
    check("R8 index reg kept", idx_count, 3);
    check("R8 vertex reg zeroed", vtx_count, 0);
    @(negedge clk);

    // R9 illegal instance bits
    send(3'd1, '0, 1'b1, 1'b1);
    check("R9 illegal pulse", illegal_inst, 1);
    @(negedge clk);
    check("R9 pulse one cycle", illegal_inst, 0);
    send(3'd1, '0, 1'b1, 1'b0);
    check("R9 legal begin", illegal_inst, 0);

    // R10 backpressure
    cmd_ready = 1'b0;
    send(3'd4, 2, 1'b0, 1'b0);
    send(3'd2, '0, 1'b0, 1'b0);
    send(3'd5, '0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      check("R10 in_ready low", in_ready, 0);
      check("R10 cmd held", {cmd_valid, cmd_count[15:0], cmd_instances}, {1'b1, 16'd2, 16'd1});
      @(negedge clk);
    end
    expect_cmd(2'd2, 2, 1, 1'b0);
    @(posedge clk);
    #1 cmd_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 released", in_ready, 1);

    repeat (2) @(negedge clk);
    check("R2 all commands seen", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule